// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of equal width and returns the full double-width signed product. It works iteratively. A single-cycle start pulse latches the multiplicand and places the multiplier in the low half of a shifting accumulator. Each following cycle recodes a three-bit slice of the multiplier. That slice is the two bits next in line plus the bit retired just before them, so consecutive slices share one bit, and below the least significant bit an implicit zero is used. The recoded value picks one multiple of the multiplicand: zero, plus or minus one times, or plus or minus two times. The doubled multiple is obtained by a one-bit left shift.

The picked multiple is added to or subtracted from the upper part of the accumulator, which carries two guard bits. The whole register is then shifted right by two places with the sign copied into the vacated positions. Because two multiplier bits retire per cycle, a WIDTH-bit multiply needs WIDTH/2 cycles. At the end, done rises and the product is held until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted and after its release with no start yet, done is 0 and product is all zeros.
- R2: A start sampled high while no multiplication is running is accepted: the operands are captured at that edge and done is 0 in the following cycle.
- R3: done rises exactly WIDTH/2 clock edges after the edge that accepted start and stays low in between; WIDTH must be even.
- R4: When done rises, product equals the signed product of the two operands captured at the accepted start, as a 2*WIDTH-bit two's-complement value.
- R5: Operands at the extremes (most negative, most positive, minus one, zero), in every pairing, give the exact product, including most-negative times most-negative = 2^(2*WIDTH-2).
- R6: A start pulse or operand change during a running multiplication has no effect: the product and the completion cycle are those of the accepted operands.
- R7: After done rises, done and product hold their values regardless of operand changes until the next start is sampled.
- R8: Each cycle recodes the slice {two next multiplier bits, previously retired bit} as 000 and 111 to zero, 001 and 010 to +M, 011 to +2M, 100 to -2M, 101 and 110 to -M, with an implicit 0 below the multiplier LSB. Multipliers with alternating and paired bit patterns therefore give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiplication |
| multiplicand | input | WIDTH | Signed multiplicand M |
| multiplier | input | WIDTH | Signed multiplier, recoded two bits per cycle |
| done | output | 1 | High once the product is valid, until the next accepted start |
| product | output | 2*WIDTH | Signed product |

## Verification
The checker assumes that start and both operands are known values at every sampled edge after reset. It also assumes that the operands are meaningful only at the edge where a start is accepted. The checker keeps its own copy of those operands and its own cycle count, and it judges the result and the latency against them. The stimulus raises start for exactly one cycle between falling edges and normally leaves it low until done appears. The one deliberate exception is a stray pulse with different operands in the middle of a run, which tests that mid-run requests are ignored.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // one recode / accumulate / shift step
  } ctrlStrobes_t;

  // Magnitude picked by the recoder
  typedef enum logic [1:0] {
    MAG_ZERO = 2'd0,
    MAG_ONE  = 2'd1,
    MAG_TWO  = 2'd2
  } mulMag_t;

endpackage

// File: rtl/booth_mul_recode.sv
module booth_mul_recode
  import booth_mul_pkg::*;
(
  input  logic [2:0] window,
  output mulMag_t    magSel,
  output logic       negate
);

  always_comb begin
    unique case (window)
      3'b001, 3'b010: begin magSel = MAG_ONE;  negate = 1'b0; end
      3'b011:         begin magSel = MAG_TWO;  negate = 1'b0; end
      3'b100:         begin magSel = MAG_TWO;  negate = 1'b1; end
      3'b101, 3'b110: begin magSel = MAG_ONE;  negate = 1'b1; end
      default:        begin magSel = MAG_ZERO; negate = 1'b0; end
    endcase
  end

endmodule

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strb,
  output logic         done
);

  localparam int HALF = WIDTH / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t     state;
  logic [CW-1:0]  stepCnt;
  logic           lastStep;

  assign strb.load = (state == ST_IDLE) && start;
  assign strb.step = (state == ST_RUN);
  assign lastStep  = (stepCnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= '0;
            done    <= 1'b0;
          end
        end
        ST_RUN: begin
          if (lastStep) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/booth_mul_dp.sv
module booth_mul_dp
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);

  localparam int HW = WIDTH + 2;  // upper part with two guard bits

  logic [WIDTH-1:0] mcand;
  logic [HW-1:0]    hiAcc;
  logic [WIDTH-1:0] loAcc;
  logic             prevBit;

  logic [2:0]       window;
  mulMag_t          magSel;
  logic             negate;
  logic [HW-1:0]    mOne;
  logic [HW-1:0]    mTwo;
  logic [HW-1:0]    magnitude;
  logic [HW-1:0]    sum;

  assign window = {loAcc[1:0], prevBit};

  booth_mul_recode u_recode (
    .window (window),
    .magSel (magSel),
    .negate (negate)
  );

  assign mOne = {{2{mcand[WIDTH-1]}}, mcand};
  assign mTwo = {mOne[HW-2:0], 1'b0};

  always_comb begin
    unique case (magSel)
      MAG_ONE: magnitude = mOne;
      MAG_TWO: magnitude = mTwo;
      default: magnitude = '0;
    endcase
  end

  // Single adder/subtractor on the upper part
  assign sum = negate ? (hiAcc - magnitude) : (hiAcc + magnitude);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      hiAcc   <= '0;
      loAcc   <= '0;
      prevBit <= 1'b0;
    end else if (strb.load) begin
      mcand   <= multiplicand;
      hiAcc   <= '0;
      loAcc   <= multiplier;
      prevBit <= 1'b0;
    end else if (strb.step) begin
      hiAcc   <= {{2{sum[HW-1]}}, sum[HW-1:2]};
      loAcc   <= {sum[1:0], loAcc[WIDTH-1:2]};
      prevBit <= loAcc[1];
    end
  end

  assign product = {hiAcc[WIDTH-1:0], loAcc};

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  ctrlStrobes_t strb;

  booth_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  booth_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int HALF = WIDTH / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic              chkRun;
  logic [CW-1:0]     chkCnt;
  logic [WIDTH-1:0]  capA;
  logic [WIDTH-1:0]  capB;
  logic [2*WIDTH-1:0] expProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkRun <= 1'b0;
      chkCnt <= '0;
      capA   <= '0;
      capB   <= '0;
    end else if (!chkRun && start) begin
      chkRun <= 1'b1;
      chkCnt <= '0;
      capA   <= multiplicand;
      capB   <= multiplier;
    end else if (chkRun) begin
      if (chkCnt == CW'(HALF - 1)) chkRun <= 1'b0;
      else                         chkCnt <= chkCnt + 1'b1;
    end
  end

  assign expProd = $signed({{WIDTH{capA[WIDTH-1]}}, capA}) *
                   $signed({{WIDTH{capB[WIDTH-1]}}, capB});

  initial begin
    AST_WIDTH_EVEN: assert (WIDTH >= 2 && WIDTH % 2 == 0); // R3
  end

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !chkRun) |=> !done); // R2

  AST_NO_DONE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    chkRun |-> !done); // R3

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(chkRun) && $past(chkCnt) == CW'(HALF - 1))); // R3

  AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (product == expProd)); // R4

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(product))); // R7

endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .done         (done),
  .product      (product)
);

// File: tb/booth_mul_tb.sv
module booth_mul_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        st4 = 1'b0, st8 = 1'b0, st16 = 1'b0;
  logic [3:0]  mc4 = '0, mp4 = '0;
  logic [7:0]  mc8 = '0, mp8 = '0;
  logic [15:0] mc16 = '0, mp16 = '0;
  logic        done4, done8, done16;
  logic [7:0]  prod4;
  logic [15:0] prod8;
  logic [31:0] prod16;

  int checks = 0;
  int errors = 0;
  longint q4[$], q8[$], q16[$];
  string  t4[$], t8[$], t16[$];
  longint lastExp8 = 0;

  booth_mul #(.WIDTH(8)) u_dut (
    .clk(clk), .rstN(rstN), .start(st8), .multiplicand(mc8), .multiplier(mp8),
    .done(done8), .product(prod8));

  booth_mul #(.WIDTH(4)) u_dut4 (
    .clk(clk), .rstN(rstN), .start(st4), .multiplicand(mc4), .multiplier(mp4),
    .done(done4), .product(prod4));

  booth_mul #(.WIDTH(16)) u_dut16 (
    .clk(clk), .rstN(rstN), .start(st16), .multiplicand(mc16), .multiplier(mp16),
    .done(done16), .product(prod16));

  function automatic logic doneOf(input int w);
    case (w)
      4:       return done4;
      8:       return done8;
      default: return done16;
    endcase
  endfunction

  task automatic setStart(input int w, input logic v);
    case (w)
      4:       st4 = v;
      8:       st8 = v;
      default: st16 = v;
    endcase
  endtask

  task automatic setOps(input int w, input int a, input int b);
    case (w)
      4:       begin mc4 = a[3:0];   mp4 = b[3:0];   end
      8:       begin mc8 = a[7:0];   mp8 = b[7:0];   end
      default: begin mc16 = a[15:0]; mp16 = b[15:0]; end
    endcase
  endtask

  // Driver: pushes the expected product, issues start, checks handshake timing
  task automatic runOp(input int w, input int a, input int b, input string tag,
                       input bit interfere);
    int cnt;
    longint expv;
    expv = longint'(a) * longint'(b);
    @(negedge clk);
    setOps(w, a, b);
    setStart(w, 1'b1);
    case (w)
      4:       begin q4.push_back(expv);  t4.push_back(tag);  end
      8:       begin q8.push_back(expv);  t8.push_back(tag);  lastExp8 = expv; end
      default: begin q16.push_back(expv); t16.push_back(tag); end
    endcase
    @(negedge clk);
    setStart(w, 1'b0);
    checks++;
    if (doneOf(w)) begin
      errors++;
      $display("FAIL R2 w=%0d done after accepted start: actual 1 expected 0", w);
    end
    cnt = 1;
    while (!doneOf(w)) begin
      @(negedge clk);
      cnt++;
      if (interfere && cnt == 2) begin
        setOps(w, -1 - a, 3);          // stray request mid-run (R6)
        setStart(w, 1'b1);
      end
      if (interfere && cnt == 3) setStart(w, 1'b0);
    end
    checks++;
    if (cnt != w / 2 + 1) begin
      errors++;
      $display("FAIL R3 w=%0d done latency: actual %0d expected %0d", w, cnt, w / 2 + 1);
    end
  endtask

  // Monitors: pop and compare on each rising done
  logic prev4 = 1'b0, prev8 = 1'b0, prev16 = 1'b0;

  task automatic score(input int w, input longint got, inout longint q[$], inout string t[$]);
    longint e;
    string tg;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R4 w=%0d unexpected result: actual %0d expected none", w, got);
    end else begin
      e  = q.pop_front();
      tg = t.pop_front();
      if (got != e) begin
        errors++;
        $display("FAIL %s w=%0d product: actual %0d expected %0d", tg, w, got, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (done4 && !prev4)   score(4,  longint'($signed(prod4)),  q4,  t4);
      if (done8 && !prev8)   score(8,  longint'($signed(prod8)),  q8,  t8);
      if (done16 && !prev16) score(16, longint'($signed(prod16)), q16, t16);
    end
    prev4  = done4;
    prev8  = done8;
    prev16 = done16;
  end

  task automatic corners(input int w);
    int mn, mx;
    mn = -(1 <<< (w - 1));
    mx = (1 <<< (w - 1)) - 1;
    runOp(w, mn, mn, "R5", 0);
    runOp(w, mn, mx, "R5", 0);
    runOp(w, mx, mn, "R5", 0);
    runOp(w, mx, mx, "R5", 0);
    runOp(w, mn, -1, "R5", 0);
    runOp(w, -1, mn, "R5", 0);
    runOp(w, 0, mn, "R5", 0);
    runOp(w, -1, -1, "R5", 0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done4 || done8 || done16 || prod4 != 0 || prod8 != 0 || prod16 != 0) begin
      errors++;
      $display("FAIL R1 in reset: actual done %0b%0b%0b prod %0h expected 0", done4, done8, done16, prod8);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (done4 || done8 || done16 || prod4 != 0 || prod8 != 0 || prod16 != 0) begin
      errors++;
      $display("FAIL R1 after reset: actual done %0b%0b%0b expected 000", done4, done8, done16);
    end

    // R4: exhaustive at width 4
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        runOp(4, a, b, "R4", 0);

    corners(8);
    corners(16);

    // R8: alternating and paired bit patterns in the multiplier
    runOp(8, 77, 85, "R8", 0);
    runOp(8, -77, -86, "R8", 0);
    runOp(8, 113, 51, "R8", 0);
    runOp(8, -5, -52, "R8", 0);
    runOp(16, 12345, 21845, "R8", 0);
    runOp(16, -999, -21846, "R8", 0);

    // R4: random operands at widths 8 and 16
    for (int i = 0; i < 300; i++)
      runOp(8, int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128, "R4", 0);
    for (int i = 0; i < 300; i++)
      runOp(16, int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768, "R4", 0);

    // R6: stray start mid-run is ignored
    runOp(8, -100, 93, "R6", 1);
    runOp(16, -32768, 30001, "R6", 1);

    // R7: result held while operands change and start stays low
    runOp(8, 119, -128, "R7", 0);
    @(negedge clk);
    mc8 = 8'h5A;
    mp8 = 8'hC3;
    repeat (3) @(negedge clk);
    checks++;
    if (!done8 || longint'($signed(prod8)) != lastExp8) begin
      errors++;
      $display("FAIL R7 held result: actual done=%0b prod=%0d expected done=1 prod=%0d",
               done8, $signed(prod8), lastExp8);
    end

    repeat (2) @(negedge clk);
    checks++;
    if (q4.size() + q8.size() + q16.size() != 0) begin
      errors++;
      $display("FAIL R4 pending results: actual %0d expected 0", q4.size() + q8.size() + q16.size());
    end
    finishRun();
  end

endmodule